// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 24-bit fixed-point signal processor. Each accepted operation multiplies two 24-bit operands and adds the product to one of two 56-bit accumulators, or subtracts it. Each accumulator is an 8-bit extension, a 24-bit high word and a 24-bit low word. Each operand can be read as two's-complement or unsigned, chosen per operation. When both operands are signed the product is doubled, so that the binary point of the fractional format stays in place. When requested, the new accumulator value is rounded to nearest at the boundary between the low and high words, and the low word is then cleared.

The unit has a two-stage pipeline and takes a new operation every cycle. Stage one forms the product and picks up the accumulator operand. Stage two adds, rounds and writes back. An operation that follows straight on from one aimed at the same accumulator gets the pending result through a forwarding path. Both accumulators are visible at the ports. A result strobe carries the high word of the value just written.

Top module: `fmac_unit`

## Requirements
- R1: A synchronous active-low reset clears both accumulators and the result strobe. Reset also drops any operation still in the pipeline.
- R2: `sign_mode` 2'b00 treats both operands as two's-complement. The 48-bit product is shifted left by one bit (fractional) and sign-extended to 56 bits. Example: 0x800000 × 0x800000 adds 0x00_800000_000000.
- R3: `sign_mode` bit 1 makes `op_x` unsigned and bit 0 makes `op_y` unsigned (01 and 10 are mixed, 11 is fully unsigned). In these modes the product is not shifted. It is sign-extended to 56 bits, and is negative only when a signed operand is negative.
- R4: `acc_sel` 0 targets accumulator A and 1 targets accumulator B. The accumulator that is not targeted keeps its value.
- R5: With `negate` high the product is subtracted from the target accumulator instead of added.
- R6: With `round_en` high, 2^23 is added to the new sum and bits 23..0 are then cleared. With it low the full 56-bit sum is stored.
- R7: An operation presented at clock edge k changes its accumulator at edge k+1. At that same edge `res_valid` pulses for one cycle, with `res_msp` equal to bits 47..24 of the value written.
- R8: Operations may arrive on consecutive cycles, to the same or to different accumulators. Each one uses the result of every earlier operation.
- R9: Accumulation wraps modulo 2^56, with no saturation.
- R10: While `op_valid` is low, the operand and control inputs have no effect on either accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation accepted this cycle |
| op_x | input | 24 | First multiplier operand |
| op_y | input | 24 | Second multiplier operand |
| sign_mode | input | 2 | Bit 1: op_x unsigned; bit 0: op_y unsigned |
| acc_sel | input | 1 | Target accumulator (0 = A, 1 = B) |
| negate | input | 1 | Subtract the product instead of adding it |
| round_en | input | 1 | Round the result into the high word |
| acc_a | output | 56 | Accumulator A contents |
| acc_b | output | 56 | Accumulator B contents |
| res_valid | output | 1 | A write-back happened at the last edge |
| res_msp | output | 24 | High word of the value just written |

## Verification
The hardest case to reach is the forwarding hazard. It needs an operation in stage one at the same time as a second operation for the same accumulator, and the hazard only appears with no idle cycle between them. The stimulus sends long unbroken runs of operations with a random accumulator select, which sets up many same-target and alternating pairs. These runs are mixed with directed bursts that hit one accumulator every cycle while changing rounding and negation. A separate run of 520 back-to-back maximum signed products pushes one accumulator past its 56-bit range, so the wrap is reached through the forwarding path as well.

// File: rtl/fmac_pkg.sv
// Package: shared types of the fractional multiply-accumulate unit.
// Assumes sign_mode bit 1 qualifies op_x and bit 0 qualifies op_y.
package fmac_pkg;
    typedef enum logic [1:0] {
        SM_SS = 2'b00,   // both operands two's-complement
        SM_SU = 2'b01,   // x signed, y unsigned
        SM_US = 2'b10,   // x unsigned, y signed
        SM_UU = 2'b11    // both unsigned
    } sign_mode_e;
endpackage

// File: rtl/fmac_mult.sv
// Module: fmac_mult
// Combinational multiplier. It extends each operand by one bit according to the
// sign mode, multiplies, sign-extends the result to the accumulator width and
// doubles it in signed-by-signed mode (fractional alignment).
// Assumes ACC_W >= 2*OP_W + 2.
module fmac_mult #(
    parameter int OP_W  = 24,
    parameter int ACC_W = 56
) (
    input  logic [OP_W-1:0]  x_in,
    input  logic [OP_W-1:0]  y_in,
    input  logic [1:0]       mode,
    output logic [ACC_W-1:0] prod
);
    import fmac_pkg::*;

    localparam int RAW_W = 2*OP_W + 2;
    localparam int PAD_W = ACC_W - RAW_W;

    logic        [OP_W:0]    x_ext, y_ext;
    logic signed [RAW_W-1:0] raw;
    logic        [ACC_W-1:0] wide;

    // Extend operands: an unsigned operand gets a zero on top.
    always_comb begin
        x_ext = {x_in[OP_W-1] & ~mode[1], x_in};
        y_ext = {y_in[OP_W-1] & ~mode[0], y_in};
        raw   = $signed(x_ext) * $signed(y_ext);
    end

    // Sign-extend the raw product and align it for the fractional format.
    always_comb begin
        wide = {{PAD_W{raw[RAW_W-1]}}, raw};
        if (sign_mode_e'(mode) == SM_SS)
            prod = {wide[ACC_W-2:0], 1'b0};
        else
            prod = wide;
    end
endmodule

// File: rtl/fmac_addrnd.sv
// Module: fmac_addrnd
// Combinational accumulate stage. It adds the product to the accumulator
// operand or subtracts it, then optionally rounds to nearest at the boundary
// between the low and high words and clears the low word.
// Assumes two's-complement wrap at ACC_W bits.
module fmac_addrnd #(
    parameter int OP_W  = 24,
    parameter int ACC_W = 56
) (
    input  logic [ACC_W-1:0] opnd,
    input  logic [ACC_W-1:0] prod,
    input  logic             neg,
    input  logic             rnd,
    output logic [ACC_W-1:0] sum
);
    localparam logic [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (OP_W-1);

    logic [ACC_W-1:0] raw_sum;
    logic [ACC_W-1:0] rnd_sum;

    // Add or subtract the product.
    always_comb raw_sum = neg ? (opnd - prod) : (opnd + prod);

    // Round to nearest and clear the low word when requested.
    always_comb begin
        rnd_sum = raw_sum + HALF_LSB;
        rnd_sum[OP_W-1:0] = '0;
        sum = rnd ? rnd_sum : raw_sum;
    end
endmodule

// File: rtl/fmac_accbank.sv
// Module: fmac_accbank
// Bank of NUM_ACC accumulator registers with a single write port.
// Assumes at most one write per cycle. A synchronous active-low reset clears
// every register.
module fmac_accbank #(
    parameter int NUM_ACC = 2,
    parameter int ACC_W   = 56,
    localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [SEL_W-1:0]                wr_sel,
    input  logic [ACC_W-1:0]                wr_data,
    output logic [NUM_ACC-1:0][ACC_W-1:0]   acc_q
);
    for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
        // Hold or load accumulator i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[i] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(i)))
                acc_q[i] <= wr_data;
        end

        // R1: reset leaves the accumulator cleared.
        assert_reset_clears_R1: assert property (@(posedge clk)
            !rst_n |=> (acc_q[i] == '0));

        // R4 / R10: an accumulator that is not written keeps its value.
        assert_hold_unselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_sel == SEL_W'(i))) |=> $stable(acc_q[i]));
    end
endmodule

// File: rtl/fmac_unit.sv
// Module: fmac_unit (top)
// Two-stage fractional multiply-accumulate unit with two accumulators.
// Stage 1 registers the product, the controls and the accumulator operand.
// The operand is forwarded from stage 2 when stage 2 writes the same
// accumulator. Stage 2 adds, rounds and writes back.
// Assumes one operation per cycle at most. Reset is synchronous, active low.
module fmac_unit #(
    parameter int OP_W  = 24,
    parameter int EXT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  logic [OP_W-1:0]          op_x,
    input  logic [OP_W-1:0]          op_y,
    input  logic [1:0]               sign_mode,
    input  logic                     acc_sel,
    input  logic                     negate,
    input  logic                     round_en,
    output logic [EXT_W+2*OP_W-1:0]  acc_a,
    output logic [EXT_W+2*OP_W-1:0]  acc_b,
    output logic                     res_valid,
    output logic [OP_W-1:0]          res_msp
);
    localparam int ACC_W   = EXT_W + 2*OP_W;
    localparam int NUM_ACC = 2;

    logic [ACC_W-1:0]              prod_c;
    logic [NUM_ACC-1:0][ACC_W-1:0] acc_rd;
    logic [ACC_W-1:0]              sum_c;
    logic [ACC_W-1:0]              opnd_c;
    logic                          fwd_hit;

    logic                          s1_valid;
    logic                          s1_sel;
    logic                          s1_neg;
    logic                          s1_rnd;
    logic [ACC_W-1:0]              s1_prod;
    logic [ACC_W-1:0]              s1_opnd;

    fmac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
        .x_in (op_x),
        .y_in (op_y),
        .mode (sign_mode),
        .prod (prod_c)
    );

    // Pick the accumulator operand, forwarding the pending write-back on a hazard.
    always_comb begin
        fwd_hit = s1_valid && (s1_sel == acc_sel);
        opnd_c  = fwd_hit ? sum_c : acc_rd[acc_sel];
    end

    // Stage 1 pipeline registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sel   <= 1'b0;
            s1_neg   <= 1'b0;
            s1_rnd   <= 1'b0;
            s1_prod  <= '0;
            s1_opnd  <= '0;
        end else begin
            s1_valid <= op_valid;
            if (op_valid) begin
                s1_sel  <= acc_sel;
                s1_neg  <= negate;
                s1_rnd  <= round_en;
                s1_prod <= prod_c;
                s1_opnd <= opnd_c;
            end
        end
    end

    fmac_addrnd #(.OP_W(OP_W), .ACC_W(ACC_W)) u_addrnd (
        .opnd (s1_opnd),
        .prod (s1_prod),
        .neg  (s1_neg),
        .rnd  (s1_rnd),
        .sum  (sum_c)
    );

    fmac_accbank #(.NUM_ACC(NUM_ACC), .ACC_W(ACC_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (s1_valid),
        .wr_sel  (s1_sel),
        .wr_data (sum_c),
        .acc_q   (acc_rd)
    );

    // Result strobe and high word of the value written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_msp   <= '0;
        end else begin
            res_valid <= s1_valid;
            if (s1_valid)
                res_msp <= sum_c[2*OP_W-1:OP_W];
        end
    end

    // Drive the accumulator ports.
    always_comb begin
        acc_a = acc_rd[0];
        acc_b = acc_rd[1];
    end

    // R7: an accepted operation produces a strobe two edges later.
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ##1 res_valid);

    // R1: reset drops the result strobe.
    assert_reset_strobe_R1: assert property (@(posedge clk)
        !rst_n |=> !res_valid);

    for (genvar i = 0; i < NUM_ACC; i++) begin : g_chk
        // R7: the reported high word matches the accumulator that was written.
        assert_res_matches_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (s1_valid && (s1_sel == 1'(i))) |=> (res_msp == acc_rd[i][2*OP_W-1:OP_W]));

        // R6: a rounded write-back leaves the low word clear.
        assert_round_clears_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (s1_valid && s1_rnd && (s1_sel == 1'(i))) |=> (acc_rd[i][OP_W-1:0] == '0));
    end
endmodule

// File: tb/fmac_unit_test.sv
// Bench for fmac_unit. It drives directed corner cases and then seeded random
// traffic. A sequential model computes the expected accumulators; inputs are
// driven and outputs sampled on the falling edge.
module fmac_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [23:0] op_x = '0, op_y = '0;
    logic [1:0]  sign_mode = '0;
    logic        acc_sel = 1'b0, negate = 1'b0, round_en = 1'b0;
    logic [55:0] acc_a, acc_b;
    logic        res_valid;
    logic [23:0] res_msp;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string phase_tag = "";

    typedef struct packed {
        logic        v;
        logic [23:0] x;
        logic [23:0] y;
        logic [1:0]  m;
        logic        sel;
        logic        neg;
        logic        rnd;
    } op_t;

    op_t prev1 = '0, prev2 = '0;
    logic [55:0] mdl_a = '0, mdl_b = '0;

    fmac_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_x(op_x), .op_y(op_y),
        .sign_mode(sign_mode), .acc_sel(acc_sel), .negate(negate), .round_en(round_en),
        .acc_a(acc_a), .acc_b(acc_b), .res_valid(res_valid), .res_msp(res_msp)
    );

    always #4 clk = ~clk;

    // Expected product, computed from the R2 / R3 rules.
    function automatic logic [55:0] model_prod(logic [23:0] x, logic [23:0] y, logic [1:0] m);
        longint sx, sy, p;
        sx = m[1] ? longint'({40'b0, x}) : longint'({{40{x[23]}}, x});
        sy = m[0] ? longint'({40'b0, y}) : longint'({{40{y[23]}}, y});
        p = sx * sy;
        if (m == 2'b00) p = p <<< 1;
        return p[55:0];
    endfunction

    // Expected accumulator update (R5, R6, R9).
    function automatic logic [55:0] model_acc(logic [55:0] acc, op_t o);
        logic [55:0] s, p;
        p = model_prod(o.x, o.y, o.m);
        s = o.neg ? acc - p : acc + p;
        if (o.rnd) begin
            s = s + 56'h800000;
            s[23:0] = '0;
        end
        return s;
    endfunction

    task automatic check56(string tag, logic [55:0] act, logic [55:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %014h expected %014h", tag, act, exp);
        end
    endtask

    task automatic check24(string tag, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
        end
    endtask

    // One cycle: commit the op from two cycles back, check, then drive a new op.
    task automatic step(op_t o);
        string t;
        @(negedge clk);
        if (prev2.v) begin
            if (prev2.sel) mdl_b = model_acc(mdl_b, prev2);
            else           mdl_a = model_acc(mdl_a, prev2);
        end
        t = !prev2.v ? "R10" : prev2.rnd ? "R6" : prev2.neg ? "R5" :
            (prev2.m == 2'b00) ? "R2" : "R3";
        check56({t, " R4 R8 ", phase_tag, " acc_a"}, acc_a, mdl_a);
        check56({t, " R4 R8 ", phase_tag, " acc_b"}, acc_b, mdl_b);
        check24("R7 res_valid", {23'b0, res_valid}, {23'b0, prev2.v});
        if (prev2.v)
            check24("R7 res_msp", res_msp, prev2.sel ? mdl_b[47:24] : mdl_a[47:24]);
        prev2 = prev1;
        prev1 = o;
        op_valid  = o.v;
        op_x      = o.x;
        op_y      = o.y;
        sign_mode = o.m;
        acc_sel   = o.sel;
        negate    = o.neg;
        round_en  = o.rnd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = 1'b0;
        repeat (2) @(negedge clk);
        prev1 = '0; prev2 = '0; mdl_a = '0; mdl_b = '0;
        check56("R1 acc_a after reset", acc_a, 56'h0);
        check56("R1 acc_b after reset", acc_b, 56'h0);
        check24("R1 res_valid after reset", {23'b0, res_valid}, 24'h0);
        rst_n = 1'b1;
    endtask

    function automatic op_t mk(logic [23:0] x, logic [23:0] y, logic [1:0] m,
                               logic sel, logic neg, logic rnd);
        op_t o;
        o.v = 1'b1; o.x = x; o.y = y; o.m = m; o.sel = sel; o.neg = neg; o.rnd = rnd;
        return o;
    endfunction

    function automatic op_t rnd_op();
        op_t o;
        o.v   = ($urandom % 8) != 0;
        o.x   = 24'($urandom);
        o.y   = 24'($urandom);
        o.m   = 2'($urandom);
        o.sel = 1'($urandom);
        o.neg = 1'($urandom);
        o.rnd = ($urandom % 4) == 0;
        return o;
    endfunction

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R2: 0.5 * 0.5 gives 0.25 in accumulator A.
        step(mk(24'h400000, 24'h400000, 2'b00, 1'b0, 1'b0, 1'b0));
        step('0); step('0);
        check56("R2 half times half", acc_a, 56'h00_200000_000000);
        // R2: -1 * -1 into B.
        step(mk(24'h800000, 24'h800000, 2'b00, 1'b1, 1'b0, 1'b0));
        step('0); step('0);
        check56("R2 minus one squared", acc_b, 56'h00_800000_000000);
        // R3: unsigned and mixed extremes, R5 negate, R6 round, all back to back on A.
        step(mk(24'hFFFFFF, 24'hFFFFFF, 2'b11, 1'b0, 1'b0, 1'b0));
        step(mk(24'hFFFFFF, 24'hFFFFFF, 2'b01, 1'b0, 1'b0, 1'b0));
        step(mk(24'hFFFFFF, 24'hFFFFFF, 2'b10, 1'b0, 1'b1, 1'b0));
        step(mk(24'h000001, 24'h400000, 2'b00, 1'b0, 1'b0, 1'b1));
        step(mk(24'h123456, 24'h000000, 2'b00, 1'b0, 1'b0, 1'b1));
        // R10: idle cycles with noisy inputs.
        for (int i = 0; i < 6; i++) begin
            op_t o = rnd_op();
            o.v = 1'b0;
            step(o);
        end
        // R8: burst on one accumulator every cycle.
        for (int i = 0; i < 40; i++) begin
            op_t o = rnd_op();
            o.v = 1'b1; o.sel = 1'b1;
            step(o);
        end
        // R1: reset in the middle of traffic.
        do_reset();
        // R9: wrap past 2^56 on B with back-to-back maximum signed products.
        phase_tag = "R9";
        for (int i = 0; i < 520; i++)
            step(mk(24'h800000, 24'h800000, 2'b00, 1'b1, 1'b0, 1'b0));
        phase_tag = "";
        // Random traffic.
        for (int i = 0; i < 4000; i++)
            step(rnd_op());
        step('0); step('0); step('0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule